// File: doc/BRIEF.md
# Station Address ROM Validator

This block reads a station-address ROM one byte at a time and decides whether the six-byte hardware address stored in it can be trusted. A start request begins a run. By default the block first hunts for an eight-byte sync marker in the byte stream, and it gives up if the marker does not appear within a fixed number of reads. When the skip input is high at start, the hunt is bypassed and the first byte read is taken as the first address byte.

After sync, six address bytes are captured. They are paired into little-endian 16-bit words, and these words are folded into a checksum by a doubling-and-add scheme with end-around reduction modulo 65535. Two more bytes carry the stored checksum, low byte first. The run ends with a one-cycle done pulse. An OK or error flag then holds, together with the captured address, until the next start. The run is aborted early with an error if the address is multicast or has an all-zero vendor prefix.

The ROM is modelled as a byte source. In every cycle that `rd_o` is high, the byte on `rom_byte_i` is consumed, and the source must advance to its next byte for the following cycle.

The control state machine has six states:
- ST_IDLE: waits for start. The transition *go-hunt* leads to ST_HUNT; *go-skip* leads to ST_ADDR when skip is high.
- ST_HUNT: reads bytes until the marker completes (*synced*, to ST_ADDR) or the read budget runs out (*hunt-fail*, to ST_DONE).
- ST_ADDR: reads six address bytes. It leaves early on *mcast-fail* or *prefix-fail* (to ST_DONE), or it moves on with *addr-full* to ST_SUMLO.
- ST_SUMLO: reads the stored low byte (*lo-taken*, to ST_SUMHI).
- ST_SUMHI: reads the stored high byte and compares (*compared*, to ST_DONE).
- ST_DONE: pulses done and returns with *retire* to ST_IDLE.

Top module: `addr_rom_check`

## Requirements
- R1: After reset, `rd_o`, `done_o`, `ok_o` and `err_o` are 0 and `mac_o` is all zeros.
- R2: Without skip, the block hunts for the marker FF 00 55 AA FF 00 55 AA. A byte that does not match the expected marker byte sends the match position back to the start, and that same byte is not compared against the first marker byte again.
- R3: The hunt allows at most 32 reads. A marker that completes on the 32nd read is accepted. Otherwise, after the 32nd read the run ends with an error.
- R4: With `skip_sync_i` high at start, no hunt takes place, and the first byte read is address byte 0.
- R5: Address byte k (k = 0..5, in read order) appears at `mac_o[47-8k -: 8]`, so the first byte read is the most significant.
- R6: The checksum is computed as follows. Word j is address byte 2j plus 256 times byte 2j+1. Word 0 is the initial value. For words 1 and 2, the running value is doubled, then reduced by 65535 if it exceeds 65535, and then the word is added.
- R7: After the addition of word 1, 65535 is subtracted only if the sum is greater than 65535. After the addition of word 2, it is subtracted if the sum is greater than or equal to 65535, so a final value of exactly 65535 becomes 0.
- R8: If bit 0 of address byte 0 is set, the run ends with an error right after the second address read.
- R9: If address bytes 0, 1 and 2 are all zero, the run ends with an error right after the sixth address read. Any nonzero byte among them passes this test.
- R10: The two bytes after the address form the stored checksum, low byte first. The result is OK exactly when this value equals the computed checksum; otherwise it is an error.
- R11: `done_o` is high for exactly one cycle per run. In that cycle exactly one of `ok_o` and `err_o` is high, and both flags keep their values until the next accepted start.
- R12: `rd_o` is high only while the block is hunting or reading address or checksum bytes. A run that succeeds reads exactly 8 bytes after sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a run when the block is idle |
| skip_sync_i | input | 1 | Sampled at start; high bypasses the marker hunt |
| rd_o | output | 1 | Read strobe; the byte on rom_byte_i is consumed this cycle |
| rom_byte_i | input | 8 | Current ROM byte |
| mac_o | output | 48 | Captured address, first byte read in the top octet |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Address and checksum valid, held until the next start |
| err_o | output | 1 | Run failed, held until the next start |

## Verification
The marker hunt is exercised in several ways:
- at offset zero, behind junk bytes, and after a partial marker that breaks off;
- behind a doubled leading FF, which separates a hunter that re-tests the failing byte from one that does not;
- with the marker completing on the 32nd read and on the 33rd read, which pins the read budget exactly.

Skip-mode streams cover the address checks:
- multicast and zero-prefix addresses, and a prefix with only one nonzero byte;
- a corrupted checksum and a checksum stored with its bytes swapped;
- a constructed address whose final sum lands exactly on 65535, which separates the two reduction thresholds;
- pseudo-random addresses that exercise the folding arithmetic broadly.

The number of bytes each run consumes is compared against the expected count, which shows where each abort takes place.

// File: rtl/arc_pkg.sv
package arc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_ADDR,
        ST_SUMLO,
        ST_SUMHI,
        ST_DONE
    } arc_state_e;

    // Marker byte at position k: the four-byte group FF 00 55 AA repeats.
    function automatic logic [7:0] marker_byte(input int unsigned k);
        logic [7:0] b;
        unique case (k % 4)
            0:       b = 8'hFF;
            1:       b = 8'h00;
            2:       b = 8'h55;
            default: b = 8'hAA;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/arc_sync_hunter.sv
module arc_sync_hunter #(
    parameter int BYTE_W   = 8,
    parameter int PAT_LEN  = 8,
    parameter int HUNT_MAX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              hit_o,
    output logic              exhausted_o
);
    import arc_pkg::*;

    localparam int IDX_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
    localparam int CNT_W = (HUNT_MAX > 1) ? $clog2(HUNT_MAX) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HUNT_MAX - 1);

    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             match;

    always_comb begin
        match       = (byte_i == BYTE_W'(marker_byte(int'(idx_q))));
        hit_o       = en_i && match && (idx_q == IDX_LAST);
        exhausted_o = en_i && !hit_o && (cnt_q == CNT_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
            // a mismatching byte restarts the match without being re-tested
            if (match && idx_q != IDX_LAST) idx_q <= idx_q + 1'b1;
            else                            idx_q <= '0;
        end
    end

endmodule

// File: rtl/arc_csum_acc.sv
module arc_csum_acc #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              final_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] sum_o
);
    localparam int EXT_W = WORD_W + 1;
    localparam logic [EXT_W-1:0] MODV = {1'b0, {WORD_W{1'b1}}};

    logic [WORD_W-1:0] acc_q;
    logic [EXT_W-1:0]  dbl, fold1, added, fold2;

    always_comb begin
        dbl   = {acc_q, 1'b0};
        fold1 = (dbl > MODV) ? (dbl - MODV) : dbl;
        added = fold1 + {1'b0, word_i};
        if (final_i) fold2 = (added >= MODV) ? (added - MODV) : added;
        else         fold2 = (added >  MODV) ? (added - MODV) : added;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (load_i) acc_q <= word_i;
        else if (step_i) acc_q <= fold2[WORD_W-1:0];
    end

    assign sum_o = acc_q;

endmodule

// File: rtl/addr_rom_check.sv
module addr_rom_check #(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 6,
    parameter int PAT_LEN    = 8,
    parameter int HUNT_MAX   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         skip_sync_i,
    output logic                         rd_o,
    input  logic [BYTE_W-1:0]            rom_byte_i,
    output logic [BYTE_W*ADDR_BYTES-1:0] mac_o,
    output logic                         done_o,
    output logic                         ok_o,
    output logic                         err_o
);
    import arc_pkg::*;

    localparam int MAC_W  = BYTE_W * ADDR_BYTES;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int AIDX_W = $clog2(ADDR_BYTES);
    localparam int PFX_W  = 3 * BYTE_W;
    localparam logic [AIDX_W-1:0] AIDX_LAST = AIDX_W'(ADDR_BYTES - 1);
    localparam logic [AIDX_W-1:0] AIDX_W0HI = AIDX_W'(1);

    arc_state_e        state_q, state_d;
    logic [AIDX_W-1:0] aidx_q;
    logic [MAC_W-1:0]  mac_q;
    logic [BYTE_W-1:0] lo_q;
    logic              ok_q, err_q;

    logic              go;
    logic              hunt_en, hunt_hit, hunt_out;
    logic              mcast_bad, prefix_bad, sum_match;
    logic              fail_now, pass_now;
    logic              cs_load, cs_step, cs_final;
    logic [WORD_W-1:0] cs_sum;
    logic [WORD_W-1:0] cur_word;

    assign go       = (state_q == ST_IDLE) && start_i;
    assign hunt_en  = (state_q == ST_HUNT);
    assign cur_word = {rom_byte_i, lo_q};

    arc_sync_hunter #(
        .BYTE_W  (BYTE_W),
        .PAT_LEN (PAT_LEN),
        .HUNT_MAX(HUNT_MAX)
    ) u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (go),
        .en_i       (hunt_en),
        .byte_i     (rom_byte_i),
        .hit_o      (hunt_hit),
        .exhausted_o(hunt_out)
    );

    always_comb begin
        cs_load  = (state_q == ST_ADDR) && (aidx_q == AIDX_W0HI);
        cs_step  = (state_q == ST_ADDR) && aidx_q[0] && (aidx_q != AIDX_W0HI);
        cs_final = (aidx_q == AIDX_LAST);
    end

    arc_csum_acc #(
        .WORD_W(WORD_W)
    ) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cs_load),
        .step_i (cs_step),
        .final_i(cs_final),
        .word_i (cur_word),
        .sum_o  (cs_sum)
    );

    // address checks use bytes already captured
    always_comb begin
        mcast_bad  = (aidx_q == AIDX_W0HI) && mac_q[MAC_W-BYTE_W];
        prefix_bad = (aidx_q == AIDX_LAST) && (mac_q[MAC_W-1 -: PFX_W] == '0);
        sum_match  = (cur_word == cs_sum);
    end

    // next state
    always_comb begin
        state_d  = state_q;
        fail_now = 1'b0;
        pass_now = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = skip_sync_i ? ST_ADDR : ST_HUNT;
            end
            ST_HUNT: begin
                if (hunt_hit) begin
                    state_d = ST_ADDR;
                end else if (hunt_out) begin
                    state_d  = ST_DONE;
                    fail_now = 1'b1;
                end
            end
            ST_ADDR: begin
                if (mcast_bad || prefix_bad) begin
                    state_d  = ST_DONE;
                    fail_now = 1'b1;
                end else if (aidx_q == AIDX_LAST) begin
                    state_d = ST_SUMLO;
                end
            end
            ST_SUMLO: state_d = ST_SUMHI;
            ST_SUMHI: begin
                state_d  = ST_DONE;
                pass_now = sum_match;
                fail_now = !sum_match;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aidx_q <= '0;
            mac_q  <= '0;
            lo_q   <= '0;
            ok_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (go) begin
                aidx_q <= '0;
                mac_q  <= '0;
                ok_q   <= 1'b0;
                err_q  <= 1'b0;
            end
            if (state_q == ST_ADDR) begin
                mac_q[(MAC_W-1) - int'(aidx_q)*BYTE_W -: BYTE_W] <= rom_byte_i;
                lo_q   <= rom_byte_i;
                aidx_q <= aidx_q + 1'b1;
            end
            if (state_q == ST_SUMLO) lo_q <= rom_byte_i;
            if (pass_now) ok_q  <= 1'b1;
            if (fail_now) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        rd_o   = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_HUNT, ST_ADDR, ST_SUMLO, ST_SUMHI: rd_o = 1'b1;
            ST_DONE:                              done_o = 1'b1;
            default: ;
        endcase
        mac_o = mac_q;
        ok_o  = ok_q;
        err_o = err_q;
    end

endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
    parameter int MAC_W     = 48,
    parameter int MAX_READS = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             rd_o,
    input logic             done_o,
    input logic             ok_o,
    input logic             err_o,
    input logic [MAC_W-1:0] mac_o
);
    logic [15:0] reads_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       reads_q <= '0;
        else if (start_i) reads_q <= '0;
        else if (rd_o)    reads_q <= reads_q + 1'b1;
    end

    AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        reads_q <= 16'(MAX_READS)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ok_o ^ err_o)); // R11

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ok_o, err_o}) |-> (done_o || $past(start_i))); // R11

    AST_NO_READ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_o); // R12

    AST_NO_MCAST_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> !mac_o[MAC_W-8]); // R8

    AST_NO_ZERO_PFX_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> (mac_o[MAC_W-1 -: 24] != '0)); // R9

endmodule

bind addr_rom_check arc_checker #(
    .MAC_W    (BYTE_W * ADDR_BYTES),
    .MAX_READS(HUNT_MAX + PAT_LEN + ADDR_BYTES + 2)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .rd_o   (rd_o),
    .done_o (done_o),
    .ok_o   (ok_o),
    .err_o  (err_o),
    .mac_o  (mac_o)
);

// File: tb/sim_addr_rom_check.sv
module sim_addr_rom_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        skip_sync_i = 1'b0;
    logic        rd_o;
    logic [7:0]  rom_byte_i;
    logic [47:0] mac_o;
    logic        done_o, ok_o, err_o;

    always #2 clk = ~clk;

    addr_rom_check u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .skip_sync_i(skip_sync_i),
        .rd_o       (rd_o),
        .rom_byte_i (rom_byte_i),
        .mac_o      (mac_o),
        .done_o     (done_o),
        .ok_o       (ok_o),
        .err_o      (err_o)
    );

    // ROM byte source: advances after each consumed byte
    logic [7:0] rom [0:63];
    int         ptr = 0;
    assign rom_byte_i = rom[ptr[5:0]];
    always @(posedge clk) begin
        if (start_i)   ptr <= 0;
        else if (rd_o) ptr <= ptr + 1;
    end

    int tests = 0;
    int fails = 0;

    // scoreboard
    logic        q_ok[$];
    logic [47:0] q_mac[$];
    int          q_rd[$];
    string       q_tag[$];

    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (q_ok.size() == 0) begin
                tests++; fails++;
                $display("FAIL R11 unexpected done pulse: actual done=1 expected none");
            end else begin
                logic        e_ok;
                logic [47:0] e_mac;
                int          e_rd;
                string       tg;
                e_ok = q_ok.pop_front(); e_mac = q_mac.pop_front();
                e_rd = q_rd.pop_front(); tg = q_tag.pop_front();
                tests++;
                if (ok_o !== e_ok || err_o !== !e_ok) begin
                    fails++;
                    $display("FAIL %s verdict: actual ok=%0b err=%0b expected ok=%0b err=%0b",
                             tg, ok_o, err_o, e_ok, !e_ok);
                end
                tests++;
                if (ptr != e_rd) begin
                    fails++;
                    $display("FAIL %s read count: actual %0d expected %0d", tg, ptr, e_rd);
                end
                if (e_ok) begin
                    tests++;
                    if (mac_o !== e_mac) begin
                        fails++;
                        $display("FAIL %s address: actual %h expected %h", tg, mac_o, e_mac);
                    end
                end
            end
        end
    end

    function automatic logic [15:0] ref_sum(input logic [47:0] m);
        int c;
        c = {m[39:32], m[47:40]};
        c = c * 2; if (c > 65535) c = c - 65535;
        c = c + {m[23:16], m[31:24]}; if (c > 65535) c = c - 65535;
        c = c * 2; if (c > 65535) c = c - 65535;
        c = c + {m[7:0], m[15:8]}; if (c >= 65535) c = c - 65535;
        return c[15:0];
    endfunction

    task automatic clr_rom();
        for (int i = 0; i < 64; i++) rom[i] = 8'h11;
    endtask

    task automatic put_marker(input int off);
        logic [7:0] pat [8];
        pat = '{8'hFF, 8'h00, 8'h55, 8'hAA, 8'hFF, 8'h00, 8'h55, 8'hAA};
        for (int i = 0; i < 8; i++) rom[off+i] = pat[i];
    endtask

    task automatic put_addr(input int off, input logic [47:0] m, input logic [15:0] cs);
        for (int i = 0; i < 6; i++) rom[off+i] = m[47-8*i -: 8];
        rom[off+6] = cs[7:0];
        rom[off+7] = cs[15:8];
    endtask

    task automatic run_case(input string tag, input logic skip, input logic e_ok,
                            input logic [47:0] e_mac, input int e_rd);
        int wait_cyc;
        logic h_ok, h_err;
        q_ok.push_back(e_ok); q_mac.push_back(e_mac);
        q_rd.push_back(e_rd); q_tag.push_back(tag);
        @(negedge clk);
        skip_sync_i = skip;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        skip_sync_i = 1'b0;
        wait_cyc = 0;
        while (q_ok.size() != 0 && wait_cyc < 200) begin
            @(negedge clk);
            wait_cyc++;
        end
        if (q_ok.size() != 0) begin
            tests++; fails++;
            $display("FAIL %s no done pulse: actual none expected one", tag);
            q_ok.delete(); q_mac.delete(); q_rd.delete(); q_tag.delete();
        end
        h_ok = ok_o; h_err = err_o;
        repeat (3) @(negedge clk);
        tests++; // R11 flags held, R12 idle without reads
        if (done_o !== 1'b0 || ok_o !== h_ok || err_o !== h_err || rd_o !== 1'b0) begin
            fails++;
            $display("FAIL R11/R12 %s hold: actual done=%0b ok=%0b err=%0b rd=%0b expected 0 %0b %0b 0",
                     tag, done_o, ok_o, err_o, rd_o, h_ok, h_err);
        end
    endtask

    logic [31:0] lfsr = 32'h1ACE_B00C;
    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        return x;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [47:0] a, b;
        clr_rom();
        repeat (3) @(negedge clk);
        tests++; // R1
        if (rd_o !== 0 || done_o !== 0 || ok_o !== 0 || err_o !== 0 || mac_o !== '0) begin
            fails++;
            $display("FAIL R1 reset: actual rd=%0b done=%0b ok=%0b err=%0b mac=%h expected all 0",
                     rd_o, done_o, ok_o, err_o, mac_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        tests++; // R1 after release
        if (rd_o !== 0 || done_o !== 0) begin
            fails++;
            $display("FAIL R1 idle: actual rd=%0b done=%0b expected 0 0", rd_o, done_o);
        end

        a = 48'h02_10_20_30_40_50;
        // R2 R5 R6 R10 marker at offset 0
        clr_rom(); put_marker(0); put_addr(8, a, ref_sum(a));
        run_case("R2 R5 marker at 0", 1'b0, 1'b1, a, 16);
        // R2 after junk
        clr_rom(); put_marker(5); put_addr(13, a, ref_sum(a));
        run_case("R2 marker after junk", 1'b0, 1'b1, a, 21);
        // R2 partial marker breaking off
        clr_rom(); put_marker(0); rom[6] = 8'h12; put_marker(7); put_addr(15, a, ref_sum(a));
        run_case("R2 partial restart", 1'b0, 1'b1, a, 23);
        // R2 failing byte is not re-tested: FF then marker is missed
        clr_rom(); rom[0] = 8'hFF; put_marker(1); put_addr(9, a, ref_sum(a));
        run_case("R2 no retest", 1'b0, 1'b0, a, 32);
        // R3 marker ending on read 32 accepted, on read 33 rejected
        clr_rom(); put_marker(24); put_addr(32, a, ref_sum(a));
        run_case("R3 last read ok", 1'b0, 1'b1, a, 40);
        clr_rom(); put_marker(25); put_addr(33, a, ref_sum(a));
        run_case("R3 budget exceeded", 1'b0, 1'b0, a, 32);
        // R4 skip: address at offset 0
        clr_rom(); put_addr(0, a, ref_sum(a));
        run_case("R4 skip", 1'b1, 1'b1, a, 8);
        // R8 multicast
        b = 48'h03_10_20_30_40_50;
        clr_rom(); put_addr(0, b, ref_sum(b));
        run_case("R8 multicast", 1'b1, 1'b0, b, 2);
        // R9 zero prefix, and single nonzero prefix byte passes
        b = 48'h00_00_00_12_34_56;
        clr_rom(); put_addr(0, b, ref_sum(b));
        run_case("R9 zero prefix", 1'b1, 1'b0, b, 6);
        b = 48'h00_00_01_12_34_56;
        clr_rom(); put_addr(0, b, ref_sum(b));
        run_case("R9 prefix one byte", 1'b1, 1'b1, b, 8);
        // R10 corrupted and swapped checksum
        clr_rom(); put_addr(0, a, ref_sum(a) + 16'd1);
        run_case("R10 bad checksum", 1'b1, 1'b0, a, 8);
        b = 48'h02_10_20_30_40_51;
        clr_rom(); put_addr(0, b, {ref_sum(b)[7:0], ref_sum(b)[15:8]});
        if (ref_sum(b)[7:0] != ref_sum(b)[15:8])
            run_case("R10 swapped checksum", 1'b1, 1'b0, b, 8);
        // R7 final sum exactly 65535 folds to 0; word1 makes sum 65535 after step 1
        b = 48'h02_10_FB_DF_00_00;
        clr_rom(); put_addr(0, b, 16'h0000);
        run_case("R7 final equals modulus", 1'b1, 1'b1, b, 8);
        // R6 large words, both reductions active
        b = 48'hFE_FF_FF_FF_FF_FF;
        clr_rom(); put_addr(0, b, ref_sum(b));
        run_case("R6 all high words", 1'b1, 1'b1, b, 8);
        // R6 pseudo-random addresses
        for (int k = 0; k < 6; k++) begin
            lfsr = nxt(lfsr); b[47:16] = lfsr;
            lfsr = nxt(lfsr); b[15:0] = lfsr[15:0];
            b[47:40] = (b[47:40] & 8'hFE) | 8'h02;
            clr_rom(); put_marker(k); put_addr(k + 8, b, ref_sum(b));
            run_case("R6 random", 1'b0, 1'b1, b, k + 16);
        end

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule